// File: doc/BRIEF.md
# 32-to-16-bit Bus Cycle Adapter

This block joins a 32-bit processor that sizes its bus dynamically to a 16-bit asynchronous expansion bus. The processor has a single data strobe. The expansion bus has separate upper-byte and lower-byte strobes. The adapter works out which of the two to drive from the low address bit, the transfer size and the direction. The address strobe goes straight through to the expansion side.

The expansion bus returns one transfer acknowledge. The adapter passes it through a synchroniser on the processor clock. It then returns it on one of the processor's two port-size acknowledges: the 8-bit-port line when the cycle targets the DSP, and the 16-bit-port line for every other cycle. The DSP select is captured at the start of each cycle. The acknowledge is held until the processor negates its address strobe, and it is released at once when that happens.

An early-termination mode can be enabled. In this mode the adapter ignores the expansion acknowledge and produces its own acknowledge after a programmed number of clocks. This lets the cycle end on a chosen clock edge, set well ahead of the edge where the processor samples it.

Top module: `bus_width_bridge`

## Requirements
- R1: While the address strobe is low and the strobe qualification of R3 holds, the upper strobe `xbus_uds_n` is low exactly when `cpu_a0` is 0.
- R2: Under the same conditions, the lower strobe `xbus_lds_n` is low when `cpu_a0` is 1, or when `cpu_siz` is anything other than 2'b01. The size encoding is 01 for one byte, 10 for two bytes, 11 for three bytes and 00 for four bytes.
- R3: On reads (`cpu_rw`=1) the data strobe is ignored. On writes (`cpu_rw`=0) neither expansion strobe goes low while `cpu_ds_n` is high.
- R4: `xbus_as_n` follows `cpu_as_n` with no clock delay.
- R5: In a cycle whose latched DSP select is 1, the acknowledge appears on `cpu_ack8_n` only, and `cpu_ack16_n` stays high.
- R6: In a cycle whose latched DSP select is 0, the acknowledge appears on `cpu_ack16_n` only, and `cpu_ack8_n` stays high.
- R7: With early mode off, `xbus_ack_n` driven low is seen as a processor acknowledge after the third rising clock edge, one edge per synchroniser stage plus one. It is not seen after the second edge.
- R8: With early mode on and a programmed count N, the acknowledge appears after the Nth rising edge that samples the address strobe low. A count of 0 acts like 1. `xbus_ack_n` has no effect in this mode.
- R9: Once asserted, the processor acknowledge stays low until the address strobe goes high. It goes high together with the address strobe, without waiting for a clock edge.
- R10: The DSP select is sampled on the first rising edge of a cycle. Later changes within the same cycle do not move the acknowledge to the other line.
- R11: While reset is low, both processor acknowledges and both expansion strobes are high. Whenever the address strobe is high, these four outputs are also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_as_n | input | 1 | Processor address strobe, active low |
| cpu_ds_n | input | 1 | Processor data strobe, active low |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_siz | input | 2 | Transfer size (01 byte, 10 word, 11 three bytes, 00 long) |
| cpu_a0 | input | 1 | Address bit 0 |
| dsp_sel | input | 1 | Decode: cycle targets the DSP |
| early_en | input | 1 | Enable synthesised early acknowledge |
| early_clks | input | CNT_W | Clocks from address strobe to early acknowledge |
| xbus_ack_n | input | 1 | Expansion transfer acknowledge, asynchronous, active low |
| xbus_as_n | output | 1 | Expansion address strobe |
| xbus_uds_n | output | 1 | Expansion upper-byte strobe, active low |
| xbus_lds_n | output | 1 | Expansion lower-byte strobe, active low |
| cpu_ack8_n | output | 1 | Processor 8-bit-port acknowledge, active low |
| cpu_ack16_n | output | 1 | Processor 16-bit-port acknowledge, active low |

## Verification
The assertions assume that the processor keeps its address strobe low until it sees an acknowledge. They also assume that the expansion side drops its acknowledge only after the address strobe has risen, so that a stale synchronised acknowledge cannot leak into the next cycle. The stimulus follows both rules. It releases `xbus_ack_n` only after the strobe is high and then waits several idle clocks before the next cycle. It changes `dsp_sel` in the middle of a cycle only to test that the latch holds its captured value. `early_en` and `early_clks` are changed only while the bus is idle.

// File: rtl/bus_width_bridge.sv
module bus_width_bridge #(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_as_n,
  input  logic             cpu_ds_n,
  input  logic             cpu_rw,
  input  logic [1:0]       cpu_siz,
  input  logic             cpu_a0,
  input  logic             dsp_sel,
  input  logic             early_en,
  input  logic [CNT_W-1:0] early_clks,
  input  logic             xbus_ack_n,
  output logic             xbus_as_n,
  output logic             xbus_uds_n,
  output logic             xbus_lds_n,
  output logic             cpu_ack8_n,
  output logic             cpu_ack16_n
);

  localparam logic [1:0] SIZ_BYTE = 2'b01;

  logic [SYNC_STAGES-1:0] ack_sync;
  logic [CNT_W-1:0]       cnt;
  logic [CNT_W:0]         cnt_inc;
  logic                   as_act, as_seen, dsp_lat, ack_r;
  logic                   strobe_ok, early_hit, ack_in;

  assign as_act    = rst_n & ~cpu_as_n;
  assign strobe_ok = as_act & (cpu_rw | ~cpu_ds_n);

  assign xbus_as_n  = cpu_as_n;
  assign xbus_uds_n = ~(strobe_ok & ~cpu_a0);
  assign xbus_lds_n = ~(strobe_ok & (cpu_a0 | (cpu_siz != SIZ_BYTE)));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ack_sync <= '0;
    else        ack_sync <= {ack_sync[SYNC_STAGES-2:0], ~xbus_ack_n};

  assign cnt_inc   = {1'b0, cnt} + 1'b1;
  assign early_hit = cnt_inc >= {1'b0, early_clks};
  assign ack_in    = early_en ? early_hit : ack_sync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_seen <= 1'b0;
      dsp_lat <= 1'b0;
      cnt     <= '0;
      ack_r   <= 1'b0;
    end else if (!as_act) begin
      as_seen <= 1'b0;
      cnt     <= '0;
      ack_r   <= 1'b0;
    end else begin
      as_seen <= 1'b1;
      if (!as_seen)   dsp_lat <= dsp_sel;
      if (!early_hit) cnt     <= cnt_inc[CNT_W-1:0];
      if (ack_in)     ack_r   <= 1'b1;
    end
  end

  assign cpu_ack8_n  = ~(ack_r & as_act &  dsp_lat);
  assign cpu_ack16_n = ~(ack_r & as_act & ~dsp_lat);

  logic ack_any;
  assign ack_any = ~cpu_ack8_n | ~cpu_ack16_n;

  assert_ack_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cpu_ack8_n && !cpu_ack16_n));

  assert_idle_negated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_as_n |-> (cpu_ack8_n && cpu_ack16_n && xbus_uds_n && xbus_lds_n));

  assert_ack_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ack_any) && !cpu_as_n) |-> ack_any);

  assert_line_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!cpu_ack8_n) && !cpu_as_n) |-> (!cpu_ack8_n && cpu_ack16_n));

  assert_dsp_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (as_seen && $past(as_seen) && !cpu_as_n) |-> $stable(dsp_lat));

  assert_write_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_rw && cpu_ds_n) |-> (xbus_uds_n && xbus_lds_n));

endmodule

// File: tb/tb_bus_width_bridge.sv
`timescale 1ns/1ps
module tb_bus_width_bridge;
  localparam int CNT_W = 4;

  logic clk = 0, rst_n = 0;
  logic cpu_as_n = 1, cpu_ds_n = 1, cpu_rw = 1, cpu_a0 = 0;
  logic [1:0] cpu_siz = 2'b01;
  logic dsp_sel = 0, early_en = 0, xbus_ack_n = 1;
  logic [CNT_W-1:0] early_clks = '0;
  logic xbus_as_n, xbus_uds_n, xbus_lds_n, cpu_ack8_n, cpu_ack16_n;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  bus_width_bridge #(.CNT_W(CNT_W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_as_n(cpu_as_n), .cpu_ds_n(cpu_ds_n),
    .cpu_rw(cpu_rw), .cpu_siz(cpu_siz), .cpu_a0(cpu_a0), .dsp_sel(dsp_sel),
    .early_en(early_en), .early_clks(early_clks), .xbus_ack_n(xbus_ack_n),
    .xbus_as_n(xbus_as_n), .xbus_uds_n(xbus_uds_n), .xbus_lds_n(xbus_lds_n),
    .cpu_ack8_n(cpu_ack8_n), .cpu_ack16_n(cpu_ack16_n));

  // {as_n, ds_n, rw, siz[1:0], a0, exp_uds_n, exp_lds_n}
  localparam logic [7:0] VEC [12] = '{
    8'b11101011, 8'b01101001, 8'b01101110, 8'b01110000,
    8'b01100000, 8'b01111110, 8'b01010011, 8'b00010000,
    8'b00001110, 8'b00001001, 8'b10010011, 8'b00111000};

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    // R11: reset with strobe low
    cpu_as_n = 0;
    idle(2);
    #1;
    chk("R11 reset ack8", cpu_ack8_n, 1'b1);
    chk("R11 reset ack16", cpu_ack16_n, 1'b1);
    chk("R11 reset uds", xbus_uds_n, 1'b1);
    chk("R11 reset lds", xbus_lds_n, 1'b1);
    cpu_as_n = 1;
    idle(1);
    rst_n = 1;
    idle(2);

    // R1 R2 R3 R4 strobe vectors
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      {cpu_as_n, cpu_ds_n, cpu_rw, cpu_siz, cpu_a0} = VEC[i][7:2];
      #1;
      chk($sformatf("R1 uds vec%0d", i), xbus_uds_n, VEC[i][1]);
      chk($sformatf("R2 lds vec%0d", i), xbus_lds_n, VEC[i][0]);
      chk($sformatf("R4 as vec%0d", i), xbus_as_n, VEC[i][7]);
    end
    cpu_as_n = 1; cpu_ds_n = 1; cpu_rw = 1;
    idle(3);

    // R7 R5 R10 R9: normal mode, DSP cycle
    @(negedge clk); cpu_as_n = 0; dsp_sel = 1;
    idle(2);
    xbus_ack_n = 0;
    @(negedge clk); @(negedge clk); #1;
    chk("R7 not after 2 edges", cpu_ack8_n, 1'b1);
    @(negedge clk); #1;
    chk("R7 after 3 edges", cpu_ack8_n, 1'b0);
    chk("R5 ack16 idle", cpu_ack16_n, 1'b1);
    dsp_sel = 0;
    idle(3); #1;
    chk("R10 still ack8", cpu_ack8_n, 1'b0);
    chk("R10 ack16 high", cpu_ack16_n, 1'b1);
    chk("R9 held", cpu_ack8_n, 1'b0);
    @(negedge clk); cpu_as_n = 1; #1;
    chk("R9 release same time", cpu_ack8_n, 1'b1);
    xbus_ack_n = 1;
    idle(5);

    // R6: normal mode, non-DSP cycle
    @(negedge clk); cpu_as_n = 0; dsp_sel = 0;
    idle(1);
    xbus_ack_n = 0;
    idle(3); #1;
    chk("R6 ack16 low", cpu_ack16_n, 1'b0);
    chk("R6 ack8 high", cpu_ack8_n, 1'b1);
    @(negedge clk); cpu_as_n = 1; #1;
    chk("R9 ack16 release", cpu_ack16_n, 1'b1);
    xbus_ack_n = 1;
    idle(5);

    // R8: early mode N=3, expansion ack held low (ignored)
    early_en = 1; early_clks = 4'd3; xbus_ack_n = 0;
    idle(4);
    @(negedge clk); cpu_as_n = 0; #1;
    chk("R8 none before edge", cpu_ack16_n, 1'b1);
    @(negedge clk); #1;
    chk("R8 none after 1", cpu_ack16_n, 1'b1);
    @(negedge clk); #1;
    chk("R8 none after 2", cpu_ack16_n, 1'b1);
    @(negedge clk); #1;
    chk("R8 ack after 3", cpu_ack16_n, 1'b0);
    @(negedge clk); cpu_as_n = 1;
    xbus_ack_n = 1;
    idle(4);

    // R8: N=0 behaves as 1, DSP target (R5)
    early_clks = 4'd0;
    @(negedge clk); cpu_as_n = 0; dsp_sel = 1; #1;
    chk("R8 n0 none before edge", cpu_ack8_n, 1'b1);
    @(negedge clk); #1;
    chk("R8 n0 ack after 1", cpu_ack8_n, 1'b0);
    chk("R5 early ack16 high", cpu_ack16_n, 1'b1);
    @(negedge clk); cpu_as_n = 1; #1;
    chk("R11 idle ack8", cpu_ack8_n, 1'b1);
    idle(4);

    // R8: N=15, expansion ack low never terminates early
    early_clks = 4'd15;
    @(negedge clk); cpu_as_n = 0; dsp_sel = 0; xbus_ack_n = 0;
    idle(14); #1;
    chk("R8 n15 none after 14", cpu_ack16_n, 1'b1);
    @(negedge clk); #1;
    chk("R8 n15 ack after 15", cpu_ack16_n, 1'b0);
    @(negedge clk); cpu_as_n = 1; xbus_ack_n = 1;
    early_en = 0;
    idle(4);

    finish_run();
  end
endmodule